// File: doc/BRIEF.md
# Recursive Twiddle Factor Generator

This block supplies the complex twiddle factors of a long FFT on demand, so the factors do not need a full sine/cosine memory. It keeps one point of the unit circle in a register. On every advance request it emits that point and replaces it with its product with a constant complex rotation step, which is the phase increment between neighbouring coefficients. Each rotation rounds the result, and rounding error grows with the number of rotations. To keep the error bounded, the coefficient sequence is divided into equal segments. At the first index of every segment the register is loaded from a small table of exactly quantised circle points instead of from the multiplier.

With the default parameters the block serves a 16384-point transform. It delivers 8192 coefficients `exp(-j*2*pi*k/16384)` for k = 0..8191, in rising index order, and then wraps to index 0. The sequence consists of 8 segments of 1024 steps. The reload table holds `exp(-j*2*pi*m/16)` for m = 0..7. Each output component is an 18-bit signed value with 17 fractional bits. The running point is held with guard bits beyond the output width, and each product is rounded to nearest before it is fed back. A start pulse rewinds the sequence to index 0 at any time. Each accepted advance yields one coefficient, together with its index and a valid flag, a fixed number of cycles later.

Top module: `twg_recursive_gen`

## Requirements
- R1: While reset is held and directly after it, `coef_vld_o` is 0. Index 0 carries the value real = 2^(OUT_W-1)-1 (131071 by default) and imag = 0. This applies whether index 0 is the first coefficient after reset, the first after a start, or comes after the wrap.
- R2: An advance accepted in cycle c produces `coef_vld_o` = 1 in cycle c+LAT, with LAT = 3 by default. `coef_vld_o` is 0 in every cycle that does not follow an accepted advance by exactly LAT cycles.
- R3: Successive accepted advances emit indices 0, 1, 2, … on `coef_idx_o`, and the index wraps from 2^(LOG2_N-1)-1 (8191) to 0.
- R4: For every index k, each output component differs from cos(2πk/2^LOG2_N)·2^(OUT_W-1) (real part) and from −sin(2πk/2^LOG2_N)·2^(OUT_W-1) (imaginary part) by at most 2^-12 of full scale. With the defaults that bound is 32 LSB.
- R5: At every index that is a multiple of the segment length 2^LOG2_SEG (1024), the emitted value equals the exactly rounded reload point, within 1 LSB on each component.
- R6: Cycles without an advance change neither the index nor the stored point. The next advance continues with the following index and its correct value.
- R7: When start and advance are high in the same cycle, start wins. That advance produces no output, and the next advance emits index 0.
- R8: A start in the middle of a sequence rewinds it, so the next advance emits index 0 with the value given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Rewind the sequence to index 0; overrides adv_i |
| adv_i | input | 1 | Request the next coefficient |
| coef_re_o | output | OUT_W | Real part, signed, OUT_W-1 fractional bits |
| coef_im_o | output | OUT_W | Imaginary part, signed, OUT_W-1 fractional bits |
| coef_idx_o | output | LOG2_N-1 | Index of the emitted coefficient |
| coef_vld_o | output | 1 | The outputs hold a coefficient this cycle |

## Verification
The bench first runs two unbroken full sweeps across the 8191-to-0 wrap. The accuracy check at the last index of each segment then catches a recurrence whose rounding drifts or that uses a wrong step: such a design passes the early indices and only fails near the segment ends. The exact checks at the segment boundaries catch a reload that fires one index early or late, or that reads the wrong table entry; either fault shows up as a jump of a whole segment's phase.

Random advance gaps catch a design that keeps rotating while idle and so skips ahead. Starts that coincide with an advance catch a design that emits a stray coefficient or rewinds to index 1. A design with an off-by-one output latency fails the valid check in every cycle.

// File: rtl/twg_pkg.sv
package twg_pkg;

   localparam real PI = 3.14159265358979323846;

   // Power series evaluation, used only for elaboration-time constants.
   function automatic real f_cos(input real x);
      real term;
      real acc;
      term = 1.0;
      acc  = 1.0;
      for (int k = 1; k <= 24; k++) begin
         term = -term * x * x / real'((2 * k - 1) * (2 * k));
         acc  = acc + term;
      end
      return acc;
   endfunction

   function automatic real f_sin(input real x);
      real term;
      real acc;
      term = x;
      acc  = x;
      for (int k = 1; k <= 24; k++) begin
         term = -term * x * x / real'((2 * k) * (2 * k + 1));
         acc  = acc + term;
      end
      return acc;
   endfunction

   // Round to nearest at 'frac' fractional bits, clip to a signed 'width' range.
   function automatic longint f_quant(input real v, input int frac, input int width);
      real    q;
      longint r;
      longint hi;
      longint lo;
      q  = v * real'(longint'(1) << frac);
      if (q >= 0.0) r = longint'($rtoi(q + 0.5));
      else          r = -longint'($rtoi(0.5 - q));
      hi = (longint'(1) << (width - 1)) - 1;
      lo = -(longint'(1) << (width - 1));
      if (r > hi) r = hi;
      if (r < lo) r = lo;
      return r;
   endfunction

endpackage

// File: rtl/twg_pt_rom.sv
module twg_pt_rom
   import twg_pkg::*;
#(
   parameter int SW    = 24,
   parameter int SEL_W = 3
)(
   input  logic [SEL_W-1:0]     sel_i,
   output logic signed [SW-1:0] re_o,
   output logic signed [SW-1:0] im_o
);
   localparam int NPT = 1 << SEL_W;

   logic signed [SW-1:0] tbl_re [NPT];
   logic signed [SW-1:0] tbl_im [NPT];

   // Point m sits at angle -pi*m/NPT, the start of segment m.
   for (genvar m = 0; m < NPT; m++) begin : g_pt
      localparam real ANG = PI * real'(m) / real'(NPT);
      assign tbl_re[m] = SW'(f_quant(f_cos(ANG), SW - 1, SW));
      assign tbl_im[m] = SW'(f_quant(-f_sin(ANG), SW - 1, SW));
   end

   assign re_o = tbl_re[sel_i];
   assign im_o = tbl_im[sel_i];

endmodule

// File: rtl/twg_rot_mul.sv
module twg_rot_mul #(
   parameter int SW = 24,
   parameter int CW = 32,
   parameter int CF = 30
)(
   input  logic signed [SW-1:0] a_re,
   input  logic signed [SW-1:0] a_im,
   input  logic signed [CW-1:0] b_re,
   input  logic signed [CW-1:0] b_im,
   output logic signed [SW-1:0] y_re,
   output logic signed [SW-1:0] y_im
);
   localparam int PW = SW + CW + 1;
   localparam logic signed [PW-1:0] HALF = PW'(1) <<< (CF - 1);
   localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (SW - 1)) - PW'(1);
   localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (SW - 1));

   logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
   logic signed [PW-1:0] s_re, s_im, r_re, r_im;

   function automatic logic signed [SW-1:0] f_clip(input logic signed [PW-1:0] v);
      if (v > MAXV)      return MAXV[SW-1:0];
      else if (v < MINV) return MINV[SW-1:0];
      else               return v[SW-1:0];
   endfunction

   always_comb begin
      p_rr = PW'(a_re) * PW'(b_re);
      p_ii = PW'(a_im) * PW'(b_im);
      p_ri = PW'(a_re) * PW'(b_im);
      p_ir = PW'(a_im) * PW'(b_re);
      s_re = p_rr - p_ii + HALF;
      s_im = p_ri + p_ir + HALF;
      r_re = s_re >>> CF;
      r_im = s_im >>> CF;
      y_re = f_clip(r_re);
      y_im = f_clip(r_im);
   end

endmodule

// File: rtl/twg_out_pipe.sv
module twg_out_pipe #(
   parameter int DW  = 49,
   parameter int LAT = 3
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [DW-1:0] data_i,
   output logic          vld_o,
   output logic [DW-1:0] data_o
);
   localparam int CNT_W = $clog2(LAT + 2);

   logic [DW-1:0]  dat_q [LAT];
   logic [LAT-1:0] vld_q;

   for (genvar g = 0; g < LAT; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[g] <= 1'b0;
               dat_q[g] <= '0;
            end else begin
               vld_q[g] <= vld_i;
               dat_q[g] <= data_i;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[g] <= 1'b0;
               dat_q[g] <= '0;
            end else begin
               vld_q[g] <= vld_q[g-1];
               dat_q[g] <= dat_q[g-1];
            end
         end
      end
   end

   assign vld_o  = vld_q[LAT-1];
   assign data_o = dat_q[LAT-1];

   // In-flight accounting: accepted requests minus delivered results.
   logic [CNT_W-1:0] infl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) infl_q <= '0;
      else        infl_q <= infl_q + CNT_W'(vld_i) - CNT_W'(vld_o);
   end

   p_inflight_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      infl_q <= CNT_W'(LAT));
   p_no_orphan_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> infl_q != '0);

endmodule

// File: rtl/twg_recursive_gen.sv
module twg_recursive_gen
   import twg_pkg::*;
#(
   parameter int LOG2_N   = 14,
   parameter int OUT_W    = 18,
   parameter int STATE_W  = 24,
   parameter int STEP_W   = 32,
   parameter int LOG2_SEG = 10,
   parameter int LAT      = 3
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    adv_i,
   output logic signed [OUT_W-1:0] coef_re_o,
   output logic signed [OUT_W-1:0] coef_im_o,
   output logic [LOG2_N-2:0]       coef_idx_o,
   output logic                    coef_vld_o
);
   localparam int  IDX_W     = LOG2_N - 1;
   localparam int  SEL_W     = IDX_W - LOG2_SEG;
   localparam int  STEP_FRAC = STEP_W - 2;
   localparam int  RND_D     = STATE_W - OUT_W;
   localparam int  DW        = 2 * OUT_W + IDX_W;
   localparam real STEP_ANG  = 2.0 * PI / real'(longint'(1) << LOG2_N);

   localparam logic signed [STEP_W-1:0]  STEP_RE =
      STEP_W'(f_quant(f_cos(STEP_ANG), STEP_FRAC, STEP_W));
   localparam logic signed [STEP_W-1:0]  STEP_IM =
      STEP_W'(f_quant(-f_sin(STEP_ANG), STEP_FRAC, STEP_W));
   localparam logic signed [STATE_W-1:0] PT0_RE =
      STATE_W'(f_quant(1.0, STATE_W - 1, STATE_W));
   localparam logic signed [STATE_W-1:0] PT0_IM = '0;

   // Elaboration-time parameter checks
   if (LOG2_N < 4)                begin : g_chk_n    $error("LOG2_N must be at least 4"); end
   if (SEL_W < 1)                 begin : g_chk_seg  $error("segments must be shorter than the sequence"); end
   if (LOG2_SEG < 1)              begin : g_chk_seg1 $error("LOG2_SEG must be at least 1"); end
   if (OUT_W < 8)                 begin : g_chk_ow   $error("OUT_W must be at least 8"); end
   if (STATE_W < OUT_W)           begin : g_chk_sw   $error("STATE_W must not be below OUT_W"); end
   if (STATE_W > 31)              begin : g_chk_swm  $error("STATE_W must not exceed 31"); end
   if (STEP_W < 8 || STEP_W > 32) begin : g_chk_cw   $error("STEP_W must lie in 8..32"); end
   if (LAT < 1)                   begin : g_chk_lat  $error("LAT must be at least 1"); end

   logic [IDX_W-1:0]          idx_q, idx_nxt;
   logic signed [STATE_W-1:0] st_re, st_im;
   logic signed [STATE_W-1:0] mul_re, mul_im;
   logic signed [STATE_W-1:0] pt_re, pt_im;
   logic signed [OUT_W-1:0]   o_re, o_im;
   logic                      take, seg_edge;
   logic [DW-1:0]             pipe_q;

   assign take     = adv_i & ~start_i;
   assign idx_nxt  = idx_q + 1'b1;
   assign seg_edge = (idx_nxt[LOG2_SEG-1:0] == '0);

   twg_pt_rom #(.SW(STATE_W), .SEL_W(SEL_W)) u_rom (
      .sel_i (idx_nxt[IDX_W-1 -: SEL_W]),
      .re_o  (pt_re),
      .im_o  (pt_im)
   );

   twg_rot_mul #(.SW(STATE_W), .CW(STEP_W), .CF(STEP_FRAC)) u_mul (
      .a_re (st_re),
      .a_im (st_im),
      .b_re (STEP_RE),
      .b_im (STEP_IM),
      .y_re (mul_re),
      .y_im (mul_im)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         st_re <= PT0_RE;
         st_im <= PT0_IM;
      end else if (start_i) begin
         idx_q <= '0;
         st_re <= PT0_RE;
         st_im <= PT0_IM;
      end else if (adv_i) begin
         idx_q <= idx_nxt;
         st_re <= seg_edge ? pt_re : mul_re;
         st_im <= seg_edge ? pt_im : mul_im;
      end
   end

   // Round the guarded state down to the output width.
   if (RND_D == 0) begin : g_pass
      assign o_re = st_re;
      assign o_im = st_im;
   end else begin : g_round
      localparam int EW = STATE_W + 1;
      localparam logic signed [EW-1:0] HALF = EW'(1) <<< (RND_D - 1);
      localparam logic signed [EW-1:0] OMAX = EW'((longint'(1) << (OUT_W - 1)) - 1);
      localparam logic signed [EW-1:0] OMIN = EW'(-(longint'(1) << (OUT_W - 1)));
      logic signed [EW-1:0] w_re, w_im;
      always_comb begin
         w_re = (EW'(st_re) + HALF) >>> RND_D;
         w_im = (EW'(st_im) + HALF) >>> RND_D;
      end
      assign o_re = (w_re > OMAX) ? OUT_W'(OMAX) : (w_re < OMIN) ? OUT_W'(OMIN) : w_re[OUT_W-1:0];
      assign o_im = (w_im > OMAX) ? OUT_W'(OMAX) : (w_im < OMIN) ? OUT_W'(OMIN) : w_im[OUT_W-1:0];
   end

   twg_out_pipe #(.DW(DW), .LAT(LAT)) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (take),
      .data_i ({o_re, o_im, idx_q}),
      .vld_o  (coef_vld_o),
      .data_o (pipe_q)
   );

   assign coef_re_o  = pipe_q[DW-1 -: OUT_W];
   assign coef_im_o  = pipe_q[DW-OUT_W-1 -: OUT_W];
   assign coef_idx_o = pipe_q[IDX_W-1:0];

   p_start_rewinds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (idx_q == '0) && (st_re == PT0_RE) && (st_im == PT0_IM));
   p_start_beats_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && adv_i) |=> idx_q == '0);
   p_index_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
   p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !start_i) |=> $stable(idx_q) && $stable(st_re) && $stable(st_im));
   p_segment_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (&idx_q[LOG2_SEG-1:0])) |=> (st_re == $past(pt_re)) && (st_im == $past(pt_im)));
   p_first_point_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q == '0) |-> (st_re == PT0_RE) && (st_im == PT0_IM));

endmodule

// File: tb/tb_twg_recursive_gen.sv
module tb_twg_recursive_gen;
   localparam int  LAT   = 3;
   localparam int  NCO   = 8192;
   localparam int  SEG   = 1024;
   localparam int  TOL   = 32;
   localparam int  FULL  = 131072;
   localparam real TPI   = 6.28318530717958647692;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_i = 1'b0;
   logic               adv_i = 1'b0;
   logic signed [17:0] coef_re_o;
   logic signed [17:0] coef_im_o;
   logic [12:0]        coef_idx_o;
   logic               coef_vld_o;

   always #2 clk = ~clk;

   twg_recursive_gen #(.LAT(LAT)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .adv_i      (adv_i),
      .coef_re_o  (coef_re_o),
      .coef_im_o  (coef_im_o),
      .coef_idx_o (coef_idx_o),
      .coef_vld_o (coef_vld_o)
   );

   // Per-cycle record of what was driven: expected valid, index, and tag.
   bit rv   [64];
   int ridx [64];
   int rtag [64];
   int m = 0;
   int ref_idx = 0;
   bit gap = 0;
   bit after_start = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   function automatic string tname(input int t);
      case (t)
         1: return "R1";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         default: return "R3";
      endcase
   endfunction

   function automatic real rabs(input real v);
      return (v < 0.0) ? -v : v;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, m);
      end
   endtask

   task automatic observe();
      int  s;
      int  k;
      int  ar;
      int  ai;
      real ang;
      real er;
      real ei;
      s = (m + 64 - LAT) % 64;
      if (rv[s]) begin
         chk(coef_vld_o === 1'b1, "R2", "valid", longint'(coef_vld_o), 1);
         k  = ridx[s];
         chk(int'(coef_idx_o) == k, tname(rtag[s]), "index", longint'(coef_idx_o), k);
         ar  = int'(coef_re_o);
         ai  = int'(coef_im_o);
         ang = TPI * real'(k) / real'(2 * NCO);
         er  = $cos(ang) * real'(FULL);
         ei  = -$sin(ang) * real'(FULL);
         chk(rabs(real'(ar) - er) <= real'(TOL), "R4", "real part", ar, $rtoi(er));
         chk(rabs(real'(ai) - ei) <= real'(TOL), "R4", "imag part", ai, $rtoi(ei));
         if (k % SEG == 0) begin
            chk(rabs(real'(ar) - er) <= 1.0 && rabs(real'(ai) - ei) <= 1.0,
                "R5", "reload point real", ar, $rtoi(er));
         end
         if (k == 0) begin
            chk(ar == FULL - 1 && ai == 0, "R1", "index 0 real", ar, FULL - 1);
         end
      end else begin
         chk(coef_vld_o === 1'b0, (rtag[s] == 7) ? "R7" : "R2", "idle valid",
             longint'(coef_vld_o), 0);
      end
   endtask

   task automatic step(input bit st, input bit ad);
      int s;
      @(negedge clk);
      if (done) return;
      observe();
      start_i = st;
      adv_i   = ad;
      s = m % 64;
      rv[s]   = ad && !st;
      ridx[s] = ref_idx;
      if (!rst_n)           rtag[s] = 1;
      else if (st && ad)    rtag[s] = 7;
      else if (after_start) rtag[s] = 8;
      else if (gap)         rtag[s] = 6;
      else                  rtag[s] = 3;
      if (!rst_n) begin
         rv[s] = 1'b0;
      end else if (st) begin
         ref_idx     = 0;
         after_start = 1;
         gap         = 0;
      end else if (ad) begin
         ref_idx     = (ref_idx + 1) % NCO;
         after_start = 0;
         gap         = 0;
      end else begin
         gap = 1;
      end
      m++;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int r;
      r = $urandom(32'd7331);
      for (int i = 0; i < 64; i++) begin
         rv[i] = 1'b0; ridx[i] = 0; rtag[i] = 1;
      end
      // R1: reset state, no valid while and after reset
      for (int i = 0; i < 4; i++) step(0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) step(0, 0);
      // R3: two unbroken passes across the wrap, R4/R5 along the way
      for (int i = 0; i < 2 * NCO + 8; i++) step(0, 1);
      // R7: start and advance together, then continue
      step(1, 1);
      for (int i = 0; i < 5; i++) step(0, 1);
      // R8: start in the middle of the sequence
      for (int i = 0; i < 1500; i++) step(0, 1);
      step(1, 0);
      step(0, 0);
      for (int i = 0; i < 20; i++) step(0, 1);
      // R6: random gaps, random starts, some coinciding with an advance
      for (int i = 0; i < 30000; i++) begin
         int  v;
         bit  st;
         bit  ad;
         v  = int'($urandom % 1000);
         st = (v < 2);
         ad = (int'($urandom % 4) != 0) || (v == 0);
         step(st, ad);
      end
      for (int i = 0; i < LAT + 3; i++) step(0, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule